// File: doc/BRIEF.md
# Synchronous Burst SRAM with Flow-Through Read

This block is a synthesizable, cycle-level model of a single-clock synchronous static RAM. It holds a small word array (256 words of 32 bits by default). Every control, address and data input is sampled on the rising clock edge. Read data is not registered: once an edge has fixed the current address, the stored word reaches the output combinationally within the same cycle. An asynchronous output enable and a sleep input gate the output.

An access is started by one of two active-low address strobes. The processor-side strobe counts only while the primary chip enable is low, and its cycle is always a read. The controller-side strobe may read or write. A start loads the external address. After that, an active-low advance input steps a 2-bit counter that forms the two low address bits. The counter steps in linear order (start plus count, modulo 4) or interleaved order (start XOR count), as the mode input selects, and wraps after four beats. Writes merge a global write with four per-byte enables that are qualified by a byte-write enable.

In this model, the high-impedance state is represented by the drive flag `dataOe` going low, with `dataOut` forced to zero.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, `dataOe` is 0 and `dataOut` is 0 until an enabled start has occurred.
- R2: A start selects the device only when `ceN`=0, `ce2`=1 and `ce3N`=0. A start under any other combination writes nothing. From the following edge it leaves `dataOe`=0 and `dataOut`=0 until the next selected start.
- R3: In a write cycle, byte lane i (bits 8i+7:8i, lane i enabled by `bwN[i]`) is written when `gwN`=0, or when `bweN`=0 and `bwN[i]`=0. Any lane not enabled keeps its old value.
- R4: While a burst is active, a cycle with `advN`=0 and no start steps the 2-bit beat count by one. After four steps the count wraps back to the start address.
- R5: With `burstMode`=0, the low two address bits of beat k are (start[1:0] + k) mod 4.
- R6: With `burstMode`=1, the low two address bits of beat k are start[1:0] XOR k. The upper address bits stay at the start value in both orders.
- R7: `adspN`=0 starts an access only while `ceN`=0, and that access is always a read, even when write enables are active. When `adspN` and `adscN` are both 0, the access is a read at `addrIn`.
- R8: An `adscN`=0 start with write enables active writes `dataIn` to `addrIn` at that same edge.
- R9: Read data is flow-through. After an edge, `dataOut` shows the word at the current burst address, including a word written at that edge, before the next edge. `oeN`=1 drops `dataOe` to 0 immediately, without waiting for a clock edge.
- R10: While `sleep`=1, no write takes effect and `dataOe`=0, and the stored contents are kept.
- R11: A cycle with no start and `advN`=1 keeps the current address, so a write in that cycle goes to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset of the control state |
| addrIn | input | ADDR_W | External word address, loaded on a start |
| dataIn | input | DATA_W | Write data |
| ceN | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Second chip enable, active high |
| ce3N | input | 1 | Third chip enable, active low |
| adspN | input | 1 | Processor-side address strobe; read only; gated by ceN |
| adscN | input | 1 | Controller-side address strobe |
| advN | input | 1 | Burst advance, active low |
| bweN | input | 1 | Byte-write enable qualifying bwN, active low |
| bwN | input | DATA_W/8 | Per-lane write enables, active low |
| gwN | input | 1 | Global write of all lanes, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| burstMode | input | 1 | Burst order: 1 selects interleaved, 0 selects linear |
| sleep | input | 1 | Sleep: blocks writes and disables the output |
| dataOut | output | DATA_W | Flow-through read data; 0 while not driven |
| dataOe | output | 1 | Output drive flag; 0 represents high impedance |

## Verification
The whole array is first filled by single write starts, with a distinct pattern per address. Four-beat bursts are then read back from every start address in both orders, plus one extra advance. The data seen on each beat identifies which address was produced, so a linear sequence, an interleaved sequence, a wrong upper address or a missing wrap each give a different mismatch. All 64 combinations of global write, byte-write enable and the four lane enables are written over a cleared word, which separates the global override from the qualified per-lane path. Directed cycles cover the remaining behaviour:
- the processor strobe with the chip disabled, and both strobes at once with write enables active;
- each single chip-enable miss;
- a write attempted during sleep;
- an address-hold write;
- an output-enable change with no clock edge in between.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic load;   // capture addrIn, clear the beat count
    logic step;   // advance the beat count
    logic write;  // this edge is a write access
  } ctrlStrb_t;

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ceN,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             adspN,
  input  logic             adscN,
  input  logic             advN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             gwN,
  input  logic             oeN,
  input  logic             sleep,
  output ctrlStrb_t        strb,
  output logic [LANES-1:0] laneWe,
  output logic             outEn
);

  logic selNow, procStart, anyStart, accessNow, active;
  logic [LANES-1:0] laneReq;

  assign selNow    = !ceN && ce2 && !ce3N;
  assign procStart = !adspN && !ceN;          // processor strobe is gated by ceN
  assign anyStart  = procStart || !adscN;
  assign accessNow = anyStart ? selNow : active;

  // Merge of global write and qualified per-lane enables
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      laneReq[i] = !gwN || (!bweN && !bwN[i]);
    end
  end

  always_comb begin
    strb.load  = anyStart && selNow;
    strb.step  = !anyStart && active && !advN;
    strb.write = accessNow && !procStart && !sleep && (|laneReq);
    laneWe     = strb.write ? laneReq : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else        active <= accessNow;
  end

  assign outEn = active && !oeN && !sleep;

  a_r7_proc_read: assert property (@(posedge clk) disable iff (!rst_n)
    procStart |-> !strb.write);

  a_r2_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (anyStart && !selNow) |=> !outEn);

  a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (laneWe == '0) && !outEn);

endmodule

// File: rtl/sbsram_datapath.sv
module sbsram_datapath
  import sbsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctrlStrb_t             strb,
  input  logic [DATA_W/8-1:0]   laneWe,
  input  logic                  burstMode,
  input  logic [ADDR_W-1:0]     addrIn,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic                  outEn,
  output logic [DATA_W-1:0]     dataOut
);

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] baseAddr, rdAddr, wrAddr;
  logic [1:0]        burstCnt, nextCnt;

  function automatic logic [ADDR_W-1:0] beatAddr(input logic [ADDR_W-1:0] base,
                                                 input logic [1:0] cnt,
                                                 input logic inter);
    logic [1:0] low;
    low = inter ? (base[1:0] ^ cnt) : (base[1:0] + cnt);
    return {base[ADDR_W-1:2], low};
  endfunction

  assign nextCnt = burstCnt + 2'(strb.step);
  assign rdAddr  = beatAddr(baseAddr, burstCnt, burstMode);
  assign wrAddr  = strb.load ? addrIn : beatAddr(baseAddr, nextCnt, burstMode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseAddr <= '0;
      burstCnt <= '0;
    end else if (strb.load) begin
      baseAddr <= addrIn;
      burstCnt <= '0;
    end else begin
      burstCnt <= nextCnt;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (laneWe[i]) mem[wrAddr][i*8 +: 8] <= dataIn[i*8 +: 8];
    end
  end

  assign dataOut = outEn ? mem[rdAddr] : '0;

  a_r4_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.load, strb.step}));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && burstCnt == 2'd3) |=> (burstCnt == 2'd0));

  a_r8_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> (burstCnt == 2'd0) && (baseAddr == $past(addrIn)));

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic                ceN,
  input  logic                ce2,
  input  logic                ce3N,
  input  logic                adspN,
  input  logic                adscN,
  input  logic                advN,
  input  logic                bweN,
  input  logic [DATA_W/8-1:0] bwN,
  input  logic                gwN,
  input  logic                oeN,
  input  logic                burstMode,
  input  logic                sleep,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOe
);

  localparam int unsigned LANES = DATA_W / 8;

  ctrlStrb_t        strb;
  logic [LANES-1:0] laneWe;
  logic             outEn;

  sbsram_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ceN(ceN), .ce2(ce2), .ce3N(ce3N),
    .adspN(adspN), .adscN(adscN), .advN(advN), .bweN(bweN), .bwN(bwN),
    .gwN(gwN), .oeN(oeN), .sleep(sleep),
    .strb(strb), .laneWe(laneWe), .outEn(outEn)
  );

  sbsram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .laneWe(laneWe),
    .burstMode(burstMode), .addrIn(addrIn), .dataIn(dataIn),
    .outEn(outEn), .dataOut(dataOut)
  );

  assign dataOe = outEn;

  a_r9_oe_async: assert property (@(posedge clk) disable iff (!rst_n)
    oeN |-> !dataOe && (dataOut == '0));

endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addrIn = '0;
  logic [31:0] dataIn = '0;
  logic        ceN = 1'b0, ce2 = 1'b1, ce3N = 1'b0;
  logic        adspN = 1'b1, adscN = 1'b1, advN = 1'b1;
  logic        bweN = 1'b1, gwN = 1'b1, oeN = 1'b0;
  logic [3:0]  bwN = 4'hF;
  logic        burstMode = 1'b0, sleep = 1'b0;
  logic [31:0] dataOut;
  logic        dataOe;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  sync_burst_sram dut (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn), .dataIn(dataIn),
    .ceN(ceN), .ce2(ce2), .ce3N(ce3N), .adspN(adspN), .adscN(adscN),
    .advN(advN), .bweN(bweN), .bwN(bwN), .gwN(gwN), .oeN(oeN),
    .burstMode(burstMode), .sleep(sleep), .dataOut(dataOut), .dataOe(dataOe)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] pat(input logic [7:0] a);
    return {a, ~a, a ^ 8'h5A, a + 8'h33};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    adspN = 1'b1; adscN = 1'b1; advN = 1'b1;
    gwN = 1'b1; bweN = 1'b1; bwN = 4'hF;
    ceN = 1'b0; ce2 = 1'b1; ce3N = 1'b0; sleep = 1'b0;
  endtask

  task automatic ctrlWrite(input logic [7:0] a, input logic [31:0] d);
    idle(); adscN = 1'b0; addrIn = a; dataIn = d; gwN = 1'b0;
    tick();
  endtask

  task automatic ctrlRead(input logic [7:0] a);
    idle(); adscN = 1'b0; addrIn = a;
    tick();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp;
    logic [7:0]  ea;
    idle();
    #9;
    check("R1 reset oe", {31'd0, dataOe}, 32'd0);
    check("R1 reset data", dataOut, 32'd0);
    rst_n = 1'b1;
    tick();

    // R8 R9: fill every word, flow-through shows it at once
    for (int a = 0; a < 256; a++) begin
      ctrlWrite(8'(a), pat(8'(a)));
      check("R8 write flow-through", dataOut, pat(8'(a)));
    end

    // R4 R5 R6: bursts from every start address in both orders
    for (int m = 0; m < 2; m++) begin
      burstMode = m[0];
      for (int s = 0; s < 256; s++) begin
        idle(); adspN = 1'b0; addrIn = 8'(s);
        tick();
        check("R7 proc start read", dataOut, pat(8'(s)));
        for (int k = 1; k < 5; k++) begin
          idle(); advN = 1'b0;
          tick();
          ea[7:2] = 6'(s >> 2);
          ea[1:0] = m[0] ? (2'(s) ^ 2'(k)) : (2'(s) + 2'(k));
          check(m[0] ? "R6 interleaved beat" : "R5 linear beat", dataOut, pat(ea));
        end
      end
    end
    burstMode = 1'b0;

    // R3: all enable combinations over a cleared word
    for (int c = 0; c < 64; c++) begin
      ctrlWrite(8'h10, 32'h0);
      idle(); adscN = 1'b0; addrIn = 8'h10; dataIn = 32'hFFFF_FFFF;
      gwN = c[5]; bweN = c[4]; bwN = 4'(c);
      tick();
      for (int i = 0; i < 4; i++) begin
        exp[i*8 +: 8] = (!c[5] || (!c[4] && !c[i])) ? 8'hFF : 8'h00;
      end
      check("R3 byte merge", dataOut, exp);
    end
    ctrlWrite(8'h10, pat(8'h10));

    // R7: processor strobe ignored while ceN high
    ctrlRead(8'h20);
    idle(); adspN = 1'b0; ceN = 1'b1; addrIn = 8'h40;
    tick();
    check("R7 proc strobe gated", dataOut, pat(8'h20));
    // R7: both strobes, write enables active -> read at addrIn
    idle(); adspN = 1'b0; adscN = 1'b0; addrIn = 8'h44; gwN = 1'b0; dataIn = 32'hDEAD_BEEF;
    tick();
    check("R7 priority read", dataOut, pat(8'h44));
    ctrlRead(8'h44);
    check("R7 no write on proc start", dataOut, pat(8'h44));

    // R2: each single chip-enable miss deselects and does not write
    for (int v = 0; v < 3; v++) begin
      idle(); adscN = 1'b0; addrIn = 8'h60; gwN = 1'b0; dataIn = 32'h0BAD_0BAD;
      if (v == 0) ceN = 1'b1;
      if (v == 1) ce2 = 1'b0;
      if (v == 2) ce3N = 1'b1;
      tick();
      check("R2 deselect oe", {31'd0, dataOe}, 32'd0);
      check("R2 deselect data", dataOut, 32'd0);
      idle();
      tick();
      check("R2 stays deselected", {31'd0, dataOe}, 32'd0);
      ctrlRead(8'h60);
      check("R2 no write when deselected", dataOut, pat(8'h60));
    end

    // R10: sleep blocks writes and output, keeps contents
    idle(); sleep = 1'b1; adscN = 1'b0; addrIn = 8'h50; gwN = 1'b0; dataIn = 32'h1234_5678;
    tick();
    check("R10 sleep oe", {31'd0, dataOe}, 32'd0);
    check("R10 sleep data", dataOut, 32'd0);
    ctrlRead(8'h50);
    check("R10 contents kept", dataOut, pat(8'h50));

    // R11: hold address, write lands on the same word
    ctrlRead(8'h70);
    idle();
    tick();
    check("R11 hold read", dataOut, pat(8'h70));
    idle(); gwN = 1'b0; dataIn = 32'hA5A5_A5A5;
    tick();
    check("R11 hold write", dataOut, 32'hA5A5_A5A5);
    ctrlRead(8'h71);
    check("R11 neighbour untouched", dataOut, pat(8'h71));
    ctrlRead(8'h70);
    check("R11 word written", dataOut, 32'hA5A5_A5A5);

    // R9: output enable acts without a clock edge
    oeN = 1'b1;
    #0.5;
    check("R9 oe async off", {31'd0, dataOe}, 32'd0);
    oeN = 1'b0;
    #0.5;
    check("R9 oe async on", dataOut, 32'hA5A5_A5A5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule